// File: doc/BRIEF.md
# Inter-Core Mailbox Bank

This block holds a bank of 32-bit mailboxes that processor cores use to signal each other and to pass a start address to a waiting core. By default there are four cores, each owning four mailboxes, sixteen words in all. A core raises bits in any mailbox by writing a word to that mailbox's set address. The owner lowers bits by writing to the matching clear address. Only the 1 bits of the written word take effect. A read of either address returns the word as it stands and changes nothing.

Every mailbox drives its own level-sensitive interrupt output. That output is high for as long as at least one bit of the word is 1. The interrupt enable and steering logic outside this block takes these lines as its inputs.

Requests reach the block on a valid/ready channel. Read data returns on a second valid/ready channel. The request side back-pressures, with `req_ready` low, while a read response is waiting and the consumer holds `rsp_ready` low. A request moves only in a cycle where `req_valid` and `req_ready` are both high. A response stays stable until `rsp_ready` is seen high. Writes produce no response.

Top module: `mbox_bank`

## Requirements
- R1: After reset, every mailbox holds zero, all interrupt lines are low and `rsp_valid` is low.
- R2: A write to a set address ORs the 1 bits of `req_wdata` into that mailbox and leaves its other bits unchanged.
- R3: A write to a clear address clears the bits of that mailbox that are 1 in `req_wdata` and leaves its other bits unchanged.
- R4: `mbox_irq[i]` is high exactly while mailbox i holds a nonzero word. It follows the word in the cycle after the write is accepted.
- R5: For core c and mailbox m (each 0..3), index i = 4c+m. The set address is 0x80 + 16c + 4m and the clear address is 0xC0 + 16c + 4m.
- R6: A read of either the set or the clear address of mailbox i returns the word held in mailbox i. Reading does not change the word.
- R7: Writes to addresses outside both windows, or to addresses whose two low bits are not 00, change no mailbox. Reads of such addresses return zero.
- R8: A mailbox that starts at zero can take any full 32-bit value through one write to its set address, and that value reads back unchanged.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, no request is accepted, and `rsp_rdata` stays stable.
- R10: An accepted read makes `rsp_valid` high in the next cycle. An accepted write does not raise `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block accepts the offered request |
| req_write | input | 1 | 1 means write, 0 means read |
| req_addr | input | 8 | Byte address of the request |
| req_wdata | input | 32 | Write data: a set or clear mask |
| rsp_valid | output | 1 | Read data is available |
| rsp_ready | input | 1 | The consumer takes the read data |
| rsp_rdata | output | 32 | Read data |
| mbox_irq | output | 16 | One interrupt line per mailbox, index 4*core+mailbox |

## Verification
Set masks are written twice to one mailbox with bits that do not overlap, which shows that a set ORs into the word and does not overwrite it. Clear masks then remove part of the word and later the rest, which shows that a clear is selective and that the interrupt line drops only when the last bit goes. Every mailbox receives its own distinct pattern and is read back through its clear address, which catches any swap of core and mailbox in the address map. A full 32-bit word is deposited in one mailbox. Stray and unaligned addresses are written. A read response is held back while a write is waiting, which shows that nothing is accepted during the stall.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Kind of access a decoded address selects.
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2
  } acc_kind_e;

  // Bytes between neighbouring mailbox words.
  localparam int WORD_BYTES = 4;

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_BOX  = 16,
  parameter int SET_BASE = 'h80,
  parameter int CLR_BASE = 'hC0,
  parameter int IDX_W    = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  localparam int SPAN = NUM_BOX * WORD_BYTES;

  logic [ADDR_W:0] off_set, off_clr;
  logic            aligned, in_set, in_clr;

  always_comb begin
    off_set = {1'b0, addr} - (ADDR_W+1)'(SET_BASE);
    off_clr = {1'b0, addr} - (ADDR_W+1)'(CLR_BASE);
    aligned = (addr[1:0] == 2'b00);
    in_set  = aligned && (off_set < (ADDR_W+1)'(SPAN));
    in_clr  = aligned && (off_clr < (ADDR_W+1)'(SPAN));
    kind    = ACC_NONE;
    idx     = '0;
    if (in_set) begin
      kind = ACC_SET;
      idx  = IDX_W'(off_set >> 2);
    end else if (in_clr) begin
      kind = ACC_CLR;
      idx  = IDX_W'(off_clr >> 2);
    end
  end
endmodule

// File: rtl/mbox_word.sv
module mbox_word #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] word,
  output logic              irq
);
  logic [DATA_W-1:0] word_q, set_bits, clr_bits;

  always_comb begin
    set_bits = set_en ? mask : '0;
    clr_bits = clr_en ? mask : '0;
  end

  // Clear applies first, then set, so a set bit survives any clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (set_en || clr_en) word_q <= (word_q & ~clr_bits) | set_bits;
  end

  assign word = word_q;
  assign irq  = |word_q;
endmodule

// File: rtl/mbox_readmux.sv
module mbox_readmux #(
  parameter int NUM_BOX = 16,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 4
) (
  input  logic [DATA_W-1:0] words [NUM_BOX],
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_BOX; i++) begin
      if (hit && (idx == IDX_W'(i))) rdata = words[i];
    end
  end
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int NUM_CORES      = 4,
  parameter int BOXES_PER_CORE = 4,
  parameter int DATA_W         = 32,
  parameter int ADDR_W         = 8,
  parameter int SET_BASE       = 'h80,
  parameter int CLR_BASE       = 'hC0,
  localparam int NUM_BOX       = NUM_CORES * BOXES_PER_CORE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [NUM_BOX-1:0] mbox_irq
);
  localparam int IDX_W = (NUM_BOX > 1) ? $clog2(NUM_BOX) : 1;

  acc_kind_e         kind;
  logic [IDX_W-1:0]  idx;
  logic              take, take_wr, take_rd;
  logic [DATA_W-1:0] words [NUM_BOX];
  logic [DATA_W-1:0] rd_word;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  mbox_decode #(
    .ADDR_W(ADDR_W), .NUM_BOX(NUM_BOX), .SET_BASE(SET_BASE),
    .CLR_BASE(CLR_BASE), .IDX_W(IDX_W)
  ) u_decode (
    .addr(req_addr), .kind(kind), .idx(idx)
  );

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign take      = req_valid && req_ready;
  assign take_wr   = take && req_write;
  assign take_rd   = take && !req_write;

  for (genvar g = 0; g < NUM_BOX; g++) begin : g_box
    logic hit_g;
    assign hit_g = take_wr && (idx == IDX_W'(g));
    mbox_word #(.DATA_W(DATA_W)) u_word (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (hit_g && (kind == ACC_SET)),
      .clr_en (hit_g && (kind == ACC_CLR)),
      .mask   (req_wdata),
      .word   (words[g]),
      .irq    (mbox_irq[g])
    );
  end

  mbox_readmux #(
    .NUM_BOX(NUM_BOX), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_rdmux (
    .words(words), .hit(kind != ACC_NONE), .idx(idx), .rdata(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (take_rd) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;
endmodule

// File: rtl/mbox_bank_chk.sv
module mbox_bank_chk #(
  parameter int NUM_BOX  = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int SET_BASE = 'h80,
  parameter int CLR_BASE = 'hC0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [DATA_W-1:0]  req_wdata,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic [NUM_BOX-1:0] mbox_irq
);
  localparam int SPAN = NUM_BOX * 4;

  logic            take;
  logic [ADDR_W:0] o_set, o_clr;
  logic            stray;

  assign take  = req_valid && req_ready;
  assign o_set = {1'b0, req_addr} - (ADDR_W+1)'(SET_BASE);
  assign o_clr = {1'b0, req_addr} - (ADDR_W+1)'(CLR_BASE);
  assign stray = (req_addr[1:0] != 2'b00) ||
                 ((o_set >= (ADDR_W+1)'(SPAN)) && (o_clr >= (ADDR_W+1)'(SPAN)));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_stall_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_read_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_write) |=> rsp_valid);

  assert_write_noresp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_write) |=> !rsp_valid);

  assert_stray_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_write && stray) |=> $stable(mbox_irq));

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && req_write) |=> $stable(mbox_irq));

  for (genvar g = 0; g < NUM_BOX; g++) begin : g_irq
    assert_set_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && req_write && (req_addr == ADDR_W'(SET_BASE + 4*g)) && (req_wdata != '0))
      |=> mbox_irq[g]);
  end
endmodule

bind mbox_bank mbox_bank_chk #(
  .NUM_BOX(NUM_BOX), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .mbox_irq(mbox_irq)
);

// File: tb/test_mbox_bank.sv
`timescale 1ns/1ps
module test_mbox_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [15:0] mbox_irq;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_box [16];

  always #10 clk = ~clk;

  mbox_bank i_mbox_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .mbox_irq(mbox_irq)
  );

  function automatic logic [7:0] set_addr(int idx);
    return 8'(8'h80 + 4*idx);
  endfunction
  function automatic logic [7:0] clr_addr(int idx);
    return 8'(8'hC0 + 4*idx);
  endfunction
  function automatic logic [15:0] exp_irq();
    logic [15:0] v;
    for (int i = 0; i < 16; i++) v[i] = |exp_box[i];
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    while (!req_ready) @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    while (!req_ready) @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 read response valid", 32'(rsp_valid), 32'd1);
    d = rsp_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq after reset", 32'(mbox_irq), 32'h0);
    check("R1 rsp_valid after reset", 32'(rsp_valid), 32'h0);
    for (int i = 0; i < 16; i++) begin
      do_read(set_addr(i), d);
      check("R1 word zero after reset", d, 32'h0);
    end
  endtask

  task automatic t_set_or();
    logic [31:0] d;
    do_write(set_addr(4), 32'h0000_00F0); exp_box[4] |= 32'h0000_00F0;
    check("R10 write gives no response", 32'(rsp_valid), 32'd0);
    do_write(set_addr(4), 32'h0000_000F); exp_box[4] |= 32'h0000_000F;
    do_read(set_addr(4), d);
    check("R2 set ORs bits", d, exp_box[4]);
    do_read(clr_addr(4), d);
    check("R6 read via clear address", d, exp_box[4]);
    check("R4 irq for nonzero word", 32'(mbox_irq), 32'(exp_irq()));
  endtask

  task automatic t_clear();
    logic [31:0] d;
    do_write(clr_addr(4), 32'h0000_000F); exp_box[4] &= ~32'h0000_000F;
    do_read(set_addr(4), d);
    check("R3 partial clear", d, exp_box[4]);
    check("R4 irq stays while bits remain", 32'(mbox_irq[4]), 32'd1);
    do_write(clr_addr(4), 32'h0000_00F0); exp_box[4] &= ~32'h0000_00F0;
    do_read(set_addr(4), d);
    check("R3 full clear", d, 32'h0);
    check("R4 irq drops at zero", 32'(mbox_irq), 32'(exp_irq()));
  endtask

  task automatic t_map();
    logic [31:0] d;
    for (int i = 0; i < 16; i++) begin
      do_write(set_addr(i), 32'h5A00_0000 | (32'h1 << i));
      exp_box[i] |= 32'h5A00_0000 | (32'h1 << i);
      check("R4 irq vector after set", 32'(mbox_irq), 32'(exp_irq()));
    end
    for (int i = 0; i < 16; i++) begin
      do_read(clr_addr(i), d);
      check("R5 address map readback", d, exp_box[i]);
    end
    for (int i = 0; i < 16; i++) begin
      do_write(clr_addr(i), 32'hFFFF_FFFF); exp_box[i] = '0;
      check("R5 clear window index", 32'(mbox_irq), 32'(exp_irq()));
    end
  endtask

  task automatic t_full_word();
    logic [31:0] d;
    // core 2, mailbox 3 -> index 11, set 0xAC, clear 0xEC
    do_write(8'hAC, 32'hDEAD_BEEF); exp_box[11] = 32'hDEAD_BEEF;
    do_read(8'hAC, d);
    check("R8 full word deposit", d, 32'hDEAD_BEEF);
    do_read(8'hAC, d);
    check("R6 read has no side effect", d, 32'hDEAD_BEEF);
    do_write(8'hEC, 32'hDEAD_BEEF); exp_box[11] = '0;
    check("R8 full word cleared", 32'(mbox_irq), 32'h0);
  endtask

  task automatic t_stray();
    logic [31:0] d;
    do_write(set_addr(7), 32'h0000_0300); exp_box[7] = 32'h0000_0300;
    do_write(8'h7C, 32'hFFFF_FFFF);
    do_write(8'h00, 32'hFFFF_FFFF);
    do_write(8'h81, 32'hFFFF_FFFF);
    do_write(8'hDE, 32'hFFFF_FFFF);
    do_write(8'hC3, 32'hFFFF_FFFF);
    check("R7 stray writes ignored (irq)", 32'(mbox_irq), 32'(exp_irq()));
    do_read(set_addr(7), d);
    check("R7 stray clear did not touch word", d, 32'h0000_0300);
    do_read(8'h7C, d);
    check("R7 stray read returns zero", d, 32'h0);
    do_read(8'h9D, d);
    check("R7 unaligned read returns zero", d, 32'h0);
    do_write(clr_addr(7), 32'h0000_0300); exp_box[7] = '0;
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    do_write(set_addr(9), 32'hCAFE_0001); exp_box[9] = 32'hCAFE_0001;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = set_addr(9);
    @(negedge clk);
    check("R10 stalled read response valid", 32'(rsp_valid), 32'd1);
    held = rsp_rdata;
    check("R9 stalled data", held, 32'hCAFE_0001);
    req_write = 1'b1; req_addr = set_addr(0); req_wdata = 32'h1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 req_ready low while stalled", 32'(req_ready), 32'd0);
      check("R9 response held", rsp_rdata, held);
      check("R9 write not accepted", 32'(mbox_irq[0]), 32'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    exp_box[0] = 32'h1;
    check("R9 response consumed", 32'(rsp_valid), 32'd0);
    check("R9 write accepted after release", 32'(mbox_irq), 32'(exp_irq()));
    do_write(clr_addr(0), 32'h1); exp_box[0] = '0;
    do_write(clr_addr(9), 32'hFFFF_FFFF); exp_box[9] = '0;
    check("R3 bank empty", 32'(mbox_irq), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) exp_box[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_or();
    t_clear();
    t_map();
    t_full_word();
    t_stray();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule